// File: doc/BRIEF.md
# Ready-Polling Serial Converter Reader

This block is a synchronous master for a three-wire serial link to a delta-sigma converter that runs one conversion at a time. A start request drives chip select low. A falling chip select both starts a conversion and makes the converter freeze its busy/ready level onto the shared data line. The reader samples that level once per chip-select low interval. While the converter is still busy, the reader drives chip select high for one interval and then low again, and it samples the line again.

When the line reads low, the reader runs the serial clock and shifts in a 24-bit word, MSB first. It then returns chip select high. It splits the word into an underflow flag, an overflow flag and a 22-bit two's-complement code, and it reports the outcome with a one-cycle strobe. The strobe is one of three: a valid sample, a link error when both range flags are set, or a timeout when too many polls find the converter still busy.

The link can run in either of two clock-polarity arrangements, selected for each conversion. In the idle-high arrangement the transfer uses 24 clocks. In the idle-low arrangement it uses 25 clocks, and the first bit captured, which is the ready bit, is discarded. Every SCK level lasts a programmable number of system clocks. Choose that number so that SCK stays at or below 5 MHz.

Top module: `adc_poll_reader`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 1, and valid_o, link_err_o and timeout_o are 0.
- R2: A start_i sampled high while the reader is idle drives cs_n_o low after that same clock edge. A start_i sampled high while a conversion is in progress has no effect on the sequence.
- R3: With P = half_div_i + 1, every chip-select low interval lasts P cycles. At its end sdo_i is sampled. A 1 means busy: cs_n_o then goes high for P cycles and low again. A 0 means ready: the transfer begins.
- R4: sdo_i is never sampled while cs_n_o is high. A low level that the converter drives during a chip-select high interval does not count as ready.
- R5: If the line reads busy at the end of poll_max_i + 1 consecutive low intervals, timeout_o pulses for one cycle, cs_n_o returns high, no SCK edge occurs, and neither valid_o nor link_err_o pulses.
- R6: With spi_mode11_i = 1, sck_o idles at 1 and the transfer starts with a falling edge. Exactly 24 rising edges occur while cs_n_o is low.
- R7: With spi_mode11_i = 0, sck_o idles at 0 and exactly 25 rising edges occur. The bit captured on the first rising edge is discarded.
- R8: Each SCK level lasts P cycles. The line is captured at each rising edge and the bits are stored MSB first. Word bit 23 appears on ovf_lo_o, bit 22 on ovf_hi_o, and bits 21..0 on code_o.
- R9: The cycle after the last SCK high level ends, cs_n_o is 1, sck_o is at its idle level and a single one-cycle outcome pulse is raised. The result outputs hold until the next transfer completes.
- R10: When word bits 23 and 22 are both 1, link_err_o pulses instead of valid_o. The flags and code are still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| arst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, accepted only when idle |
| spi_mode11_i | input | 1 | 1: SCK idles high, 24 clocks; 0: SCK idles low, 25 clocks |
| half_div_i | input | DIV_W | System cycles per SCK level, minus one |
| poll_max_i | input | POLL_W | Number of re-polls allowed after the first busy reading |
| sdo_i | input | 1 | Shared data/ready line from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| code_o | output | 22 | Two's-complement conversion code |
| ovf_hi_o | output | 1 | Input above positive range (word bit 22) |
| ovf_lo_o | output | 1 | Input below negative range (word bit 23) |
| link_err_o | output | 1 | One-cycle pulse: both range flags set |
| timeout_o | output | 1 | One-cycle pulse: still busy after the last allowed poll |
| valid_o | output | 1 | One-cycle pulse: new sample on the result outputs |

## Verification
The assertions assume that the configuration inputs are copied only at the moment a start is accepted. They also assume that sdo_i settles within one SCK level, since the line is sampled only at the end of a level. The bench's converter model changes sdo_i just after a clock edge, so the line is always stable for at least one full cycle before it is sampled. While chip select is high, the model drives the line low, which would read as ready if the reader ever sampled it there. The bench changes the mode, divider and poll limit only between conversions. It issues extra start pulses only in the middle of a running sequence.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int WORD_W = 24;
  localparam int CODE_W = 22;
  localparam int BIT_LO = 23;
  localparam int BIT_HI = 22;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL_LOW,
    ST_SEL_HIGH,
    ST_CLK_LOW,
    ST_CLK_HIGH
  } rd_state_t;

  typedef struct packed {
    logic              range_lo;
    logic              range_hi;
    logic              bad_link;
    logic [CODE_W-1:0] code;
  } rd_result_t;
endpackage

// File: rtl/adc_rd_rstsync.sv
module adc_rd_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = run_i & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || wrap) cnt_d = '0;
    else                cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  // R8: with a level longer than one cycle, two ticks are never adjacent
  assert_tick_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(tick_o) && run_i && (div_i != '0)) |-> !tick_o);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int W     = 24,
  parameter int CNT_W = $clog2(W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic             bit_i,
  output logic [W-1:0]     word_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     word_q, word_d;
  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    word_d  = word_q;
    count_d = count_q;
    if (clr_i) begin
      count_d = '0;
    end else if (cap_i) begin
      word_d  = {word_q[W-2:0], bit_i};
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      word_q  <= '0;
      count_q <= '0;
    end else begin
      word_q  <= word_d;
      count_q <= count_d;
    end
  end

  assign word_o  = word_q;
  assign count_o = count_q;

  // R7: the longest transfer captures W+1 bits
  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    count_q <= CNT_W'(W + 1));
endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode
  import adc_rd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output rd_result_t        res_o
);
  always_comb begin
    res_o.range_lo = word_i[BIT_LO];
    res_o.range_hi = word_i[BIT_HI];
    res_o.bad_link = word_i[BIT_LO] & word_i[BIT_HI];
    res_o.code     = word_i[CODE_W-1:0];
  end
endmodule

// File: rtl/adc_poll_reader.sv
module adc_poll_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int POLL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              arst_n_i,
  input  logic              start_i,
  input  logic              spi_mode11_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [POLL_W-1:0] poll_max_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic [21:0]       code_o,
  output logic              ovf_hi_o,
  output logic              ovf_lo_o,
  output logic              link_err_o,
  output logic              timeout_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic rst_n;
  adc_rd_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .arst_n_i(arst_n_i), .rst_n_o(rst_n)
  );

  rd_state_t         state_q, state_d;
  logic              mode_q, mode_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [POLL_W-1:0] lim_q, lim_d;
  logic [POLL_W-1:0] polls_q, polls_d;
  logic              cs_q, cs_d;
  logic              sck_q, sck_d;
  logic              clr, cap, done, tmo;
  logic              tick;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  need;
  rd_result_t        res;
  rd_result_t        res_q;
  logic              valid_q, err_q, tmo_q;

  adc_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_n_i(rst_n), .run_i(state_q != ST_IDLE),
    .div_i(div_q), .tick_o(tick)
  );

  adc_rd_shift #(.W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_n_i(rst_n), .clr_i(clr), .cap_i(cap),
    .bit_i(sdo_i), .word_o(word), .count_o(count)
  );

  adc_rd_decode u_dec (.word_i(word), .res_o(res));

  assign need = mode_q ? CNT_W'(WORD_W) : CNT_W'(WORD_W + 1);

  // next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    div_d   = div_q;
    lim_d   = lim_q;
    polls_d = polls_q;
    clr     = 1'b0;
    cap     = 1'b0;
    done    = 1'b0;
    tmo     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SEL_LOW;
          mode_d  = spi_mode11_i;
          div_d   = half_div_i;
          lim_d   = poll_max_i;
          polls_d = '0;
          clr     = 1'b1;
        end
      end
      ST_SEL_LOW: begin
        if (tick) begin
          if (!sdo_i) begin
            state_d = ST_CLK_LOW;
          end else if (polls_q == lim_q) begin
            state_d = ST_IDLE;
            tmo     = 1'b1;
          end else begin
            state_d = ST_SEL_HIGH;
            polls_d = polls_q + POLL_W'(1);
          end
        end
      end
      ST_SEL_HIGH: begin
        if (tick) state_d = ST_SEL_LOW;
      end
      ST_CLK_LOW: begin
        if (tick) begin
          state_d = ST_CLK_HIGH;
          cap     = 1'b1;
        end
      end
      ST_CLK_HIGH: begin
        if (tick) begin
          if (count == need) begin
            state_d = ST_IDLE;
            done    = 1'b1;
          end else begin
            state_d = ST_CLK_LOW;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    cs_d = (state_d == ST_IDLE) || (state_d == ST_SEL_HIGH);
    unique case (state_d)
      ST_CLK_LOW:  sck_d = 1'b0;
      ST_CLK_HIGH: sck_d = 1'b1;
      default:     sck_d = mode_d;
    endcase
  end

  // control registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b1;
      div_q   <= '0;
      lim_q   <= '0;
      polls_q <= '0;
      cs_q    <= 1'b1;
      sck_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      div_q   <= div_d;
      lim_q   <= lim_d;
      polls_q <= polls_d;
      cs_q    <= cs_d;
      sck_q   <= sck_d;
    end
  end

  // result registers with explicit load enable
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (done) begin
      res_q <= res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      valid_q <= done & ~res.bad_link;
      err_q   <= done &  res.bad_link;
      tmo_q   <= tmo;
    end
  end

  assign cs_n_o     = cs_q;
  assign sck_o      = sck_q;
  assign code_o     = res_q.code;
  assign ovf_hi_o   = res_q.range_hi;
  assign ovf_lo_o   = res_q.range_lo;
  assign link_err_o = err_q;
  assign timeout_o  = tmo_q;
  assign valid_o    = valid_q;

  assert_valid_single_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_deselected_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (valid_o || link_err_o) |-> cs_n_o);
  assert_err_not_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(valid_o && link_err_o));
  assert_timeout_alone_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |-> (!valid_o && !link_err_o && cs_n_o));
  assert_sck_quiet_deselected_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o)) |-> $stable(sck_o));
endmodule

// File: tb/adc_poll_reader_test.sv
module adc_poll_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode11 = 1'b1;
  logic [7:0]  half_div = 8'd0;
  logic [7:0]  poll_max = 8'd0;
  logic        sdo = 1'b0;
  logic        cs_n, sck, ovf_hi, ovf_lo, link_err, tmo, valid;
  logic [21:0] code;

  int checks = 0;
  int errors = 0;

  // converter model configuration (written by the stimulus only)
  int          cfg_busy = 0;
  int          cfg_gen  = 0;
  logic [23:0] cfg_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_poll_reader uut (
    .clk_i(clk), .arst_n_i(arst_n), .start_i(start), .spi_mode11_i(mode11),
    .half_div_i(half_div), .poll_max_i(poll_max), .sdo_i(sdo),
    .cs_n_o(cs_n), .sck_o(sck), .code_o(code), .ovf_hi_o(ovf_hi),
    .ovf_lo_o(ovf_lo), .link_err_o(link_err), .timeout_o(tmo), .valid_o(valid)
  );

  // behavioural converter: reacts to pin edges just after each clock edge
  int   seen_gen = 0;
  int   falls = 0;
  int   bit_ix = -1;
  logic cs_prev = 1'b1;
  logic sck_prev = 1'b1;
  always @(posedge clk) begin
    #1;
    if (seen_gen != cfg_gen) begin
      seen_gen = cfg_gen;
      falls = 0;
    end
    if (cs_n && !cs_prev) begin
      sdo = 1'b0;                       // junk while deselected
      bit_ix = -1;
    end else if (!cs_n && cs_prev) begin
      if (falls < cfg_busy) begin
        sdo = 1'b1;
        bit_ix = -1;
      end else begin
        sdo = 1'b0;
        bit_ix = 23;
      end
      falls++;
    end else if (!cs_n && sck_prev && !sck && bit_ix >= 0) begin
      sdo = cfg_word[bit_ix];
      bit_ix--;
    end
    cs_prev = cs_n;
    sck_prev = sck;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // runs one request and compares every cycle against a timeline model
  task automatic run_conv(input bit m11, input int div, input int lim, input int busy,
                          input logic [23:0] w, input int restart_k, input string req);
    int  p, n, np, segs, total, rises, bad_cs, bad_sck, bad_pulse, first_bad;
    bit  to;
    logic sprev;
    p = div + 1;
    n = m11 ? 24 : 25;
    to = (busy > lim);
    np = to ? lim : busy;
    segs = to ? (1 + 2*lim) : (1 + 2*np + 2*n);
    total = segs * p;
    rises = 0; bad_cs = 0; bad_sck = 0; bad_pulse = 0; first_bad = -1;
    sprev = 1'b0;
    cfg_busy = busy; cfg_word = w; cfg_gen++;
    @(negedge clk);
    start = 1'b1; mode11 = m11; half_div = 8'(div); poll_max = 8'(lim);
    @(posedge clk);
    for (int k = 0; k < total; k++) begin
      int  seg, rel;
      logic ecs, esck;
      @(negedge clk);
      start = (k == restart_k);
      seg = k / p;
      if (seg < 1 + 2*np) begin
        ecs = (seg % 2 == 1);
        esck = m11;
      end else begin
        rel = seg - (1 + 2*np);
        ecs = 1'b0;
        esck = (rel % 2 == 1);
      end
      if (cs_n !== ecs) begin bad_cs++; if (first_bad < 0) first_bad = k; end
      if (sck !== esck) begin bad_sck++; if (first_bad < 0) first_bad = k; end
      if (valid || link_err || tmo) bad_pulse++;
      if (k > 0 && !cs_n && sck && !sprev) rises++;
      sprev = sck;
    end
    @(negedge clk);
    start = 1'b0;
    chk(bad_cs == 0, req, "R3 cs_n timeline mismatches", bad_cs, 0);
    chk(bad_sck == 0, req, "R8 sck timeline mismatches", bad_sck, 0);
    chk(bad_pulse == 0, req, "R9 early outcome pulse", bad_pulse, 0);
    chk(rises == (to ? 0 : n), req, m11 ? "R6 rising edges" : "R7 rising edges",
        rises, to ? 0 : n);
    chk(cs_n === 1'b1 && sck === m11, req, "R9 pins at completion",
        {cs_n, sck}, {1'b1, m11});
    if (to) begin
      chk(tmo && !valid && !link_err, req, "R5 timeout pulse", {tmo, valid, link_err}, 3'b100);
    end else begin
      bit both;
      both = w[23] & w[22];
      chk(valid == !both && link_err == both, req, "R10 outcome kind",
          {valid, link_err}, {!both, both});
      chk(code == w[21:0] && ovf_lo == w[23] && ovf_hi == w[22], req,
          "R8 result fields", {ovf_lo, ovf_hi, code}, w);
    end
    @(negedge clk);
    chk(!valid && !link_err && !tmo, req, "R9 pulse lasts one cycle",
        {valid, link_err, tmo}, 0);
    if (first_bad >= 0) $display("  first timeline mismatch at cycle %0d", first_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b1 && !valid && !link_err && !tmo, "R1",
        "reset state", {cs_n, sck, valid, link_err, tmo}, 5'b11000);

    run_conv(1'b1, 1, 4, 0, 24'h0ABCDE, -1, "R6");
    run_conv(1'b1, 2, 5, 3, 24'h3FF001, -1, "R3 R4");
    run_conv(1'b0, 0, 3, 1, 24'h412345, -1, "R7");
    run_conv(1'b0, 3, 2, 0, 24'hC00055, -1, "R10");
    run_conv(1'b1, 1, 2, 10, 24'h000000, -1, "R5");
    run_conv(1'b1, 0, 0, 0, 24'h8A5A5A, -1, "R8 limit0");
    run_conv(1'b0, 1, 0, 1, 24'h111111, -1, "R5 limit0");
    run_conv(1'b1, 2, 4, 2, 24'h255AA3, 7, "R2 restart ignored");
    run_conv(1'b0, 2, 4, 1, 24'h2AAAAA, 40, "R2 restart in transfer");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    $display("FAIL watchdog run did not finish actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule